// File: doc/BRIEF.md
# PLL Output Rate Calculator and Rate Rounder

This unit works out the frequency a PLL actually delivers from the divider fields held in its control words and the rate of its reference clock. The fields are stored as value minus one. The result is the reference rate multiplied by the feedback factor, then divided by the input divider, then divided by the output divider. A bypass bit forces the result to the reference rate. The arithmetic is sequential: a shift-add multiplier feeds two back-to-back restoring dividers. A request is taken only while the unit is idle. The result appears together with a one-cycle valid strobe.

A second, independent path maps a requested frequency onto a parameterised table of supported rates. The table is held from highest to lowest. A zero entry ends it early. The path returns the first entry not above the request. A request below every live entry gets the smallest live entry. A power-state output reports the PLL as running whenever the power-down bit is clear.

Top module: `pll_rate_calc`

## Requirements
- R1: When bit 0 of `ctrl3` is set at the accepted `start`, the result equals `parent_rate` (zero-extended) and the divider fields play no part.
- R2: The fields are decoded from fixed positions: feedback from `ctrl1[12:0]`, input divider from `ctrl0[13:8]`, output divider from `ctrl0[3:0]`. All other bits of the control words have no effect on the result.
- R3: Without bypass, the result is floor(floor(parent × (fb+1) / (in+1)) / (out+1)), held at full width with no truncation.
- R4: `start` is accepted only while `busy` is low. `busy` stays high from the cycle after acceptance through the cycle in which `rate_valid` is high. `rate_valid` is high for exactly one cycle. A `start` raised while busy is ignored and does not change the result in progress.
- R5: `round_rate` is registered one cycle after `req_rate`. It equals the lowest-index live table entry that is less than or equal to the request, so a request at or above the top entry returns the top entry.
- R6: A request below every live entry returns the last live entry.
- R7: Table entry 0 is the highest rate. The first zero entry ends the table, and no entry after it is ever returned.
- R8: `pll_enabled` is high exactly when bit 1 of `ctrl3` is low.
- R9: After reset, `busy`, `rate_valid`, `rate_out` and `round_rate` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Request a rate computation |
| parent_rate | input | RATE_W | Reference clock rate |
| ctrl0 | input | 16 | Control word holding input and output dividers |
| ctrl1 | input | 16 | Control word holding the feedback factor |
| ctrl3 | input | 16 | Control word with bypass (bit 0) and power-down (bit 1) |
| req_rate | input | RATE_W | Rate to be rounded to the table |
| busy | output | 1 | Computation in progress |
| rate_valid | output | 1 | One-cycle strobe marking a fresh result |
| rate_out | output | RATE_W+NF_W+1 | Computed output rate |
| pll_enabled | output | 1 | PLL reported powered |
| round_rate | output | RATE_W | Rounded supported rate |

## Verification
The bench keeps the default field widths and 32-bit rates. This lets random reference rates reach the full 46-bit product, and lets the largest feedback, input and output divider codes run through both division stages. It overrides the rate table with six live entries, a zero marker and a nonzero entry after the marker. With that table, a request below the smallest live rate shows whether the scan stops at the marker or wrongly returns the trailing entry.

// File: rtl/pll_rate_calc.sv
module pll_rate_calc #(
  parameter int RATE_W = 32,
  parameter int NF_W   = 13,
  parameter int NR_W   = 6,
  parameter int NO_W   = 4,
  parameter int TBL_N  = 8,
  parameter logic [TBL_N*RATE_W-1:0] RATE_TBL = {
    32'd0,      32'd126000, 32'd312000,  32'd408000,
    32'd600000, 32'd816000, 32'd1008000, 32'd1200000}
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [RATE_W-1:0]        parent_rate,
  input  logic [15:0]              ctrl0,
  input  logic [15:0]              ctrl1,
  input  logic [15:0]              ctrl3,
  input  logic [RATE_W-1:0]        req_rate,
  output logic                     busy,
  output logic                     rate_valid,
  output logic [RATE_W+NF_W:0]     rate_out,
  output logic                     pll_enabled,
  output logic [RATE_W-1:0]        round_rate
);
  localparam int PW = RATE_W + NF_W + 1;
  localparam int MW = NF_W + 1;
  localparam int DW = ((NR_W > NO_W) ? NR_W : NO_W) + 1;
  localparam int CW = $clog2(PW + 1);

  typedef enum logic [2:0] {S_IDLE, S_MUL, S_DIV1, S_DIV2, S_DONE} st_t;
  st_t state;

  logic [CW-1:0]   cnt;
  logic [PW-1:0]   acc, mcand;
  logic [MW-1:0]   mplr;
  logic [DW-1:0]   rem, dva, dvb, dsr;
  logic [DW:0]     sh, sub;
  logic            ge;

  wire [NF_W-1:0] nf = ctrl1[NF_W-1:0];
  wire [NR_W-1:0] nr = ctrl0[8 +: NR_W];
  wire [NO_W-1:0] no = ctrl0[NO_W-1:0];

  assign busy        = (state != S_IDLE);
  assign rate_valid  = (state == S_DONE);
  assign rate_out    = acc;
  assign pll_enabled = ~ctrl3[1];

  assign dsr = (state == S_DIV1) ? dva : dvb;
  assign sh  = {rem, acc[PW-1]};
  assign ge  = (sh >= {1'b0, dsr});
  assign sub = sh - {1'b0, dsr};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
      acc   <= '0;
      mcand <= '0;
      mplr  <= '0;
      rem   <= '0;
      dva   <= '0;
      dvb   <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          if (ctrl3[0]) begin
            acc   <= PW'(parent_rate);
            state <= S_DONE;
          end else begin
            acc   <= '0;
            mcand <= PW'(parent_rate);
            mplr  <= MW'(nf) + MW'(1);
            dva   <= DW'(nr) + DW'(1);
            dvb   <= DW'(no) + DW'(1);
            cnt   <= '0;
            state <= S_MUL;
          end
        end
        S_MUL: begin
          if (mplr[0]) acc <= acc + mcand;
          mcand <= mcand << 1;
          mplr  <= mplr >> 1;
          cnt   <= cnt + 1'b1;
          if (cnt == CW'(MW - 1)) begin
            cnt   <= '0;
            rem   <= '0;
            state <= S_DIV1;
          end
        end
        S_DIV1, S_DIV2: begin
          acc <= {acc[PW-2:0], ge};
          rem <= ge ? sub[DW-1:0] : sh[DW-1:0];
          cnt <= cnt + 1'b1;
          if (cnt == CW'(PW - 1)) begin
            cnt   <= '0;
            rem   <= '0;
            state <= (state == S_DIV1) ? S_DIV2 : S_DONE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  logic [RATE_W-1:0] pick, last_live, round_d;
  logic              live, hit;

  always_comb begin
    live = 1'b1;
    hit  = 1'b0;
    pick = '0;
    last_live = '0;
    for (int i = 0; i < TBL_N; i++) begin
      if (RATE_TBL[i*RATE_W +: RATE_W] == '0) live = 1'b0;
      if (live) begin
        last_live = RATE_TBL[i*RATE_W +: RATE_W];
        if (!hit && RATE_TBL[i*RATE_W +: RATE_W] <= req_rate) begin
          hit  = 1'b1;
          pick = RATE_TBL[i*RATE_W +: RATE_W];
        end
      end
    end
    round_d = hit ? pick : last_live;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) round_rate <= '0;
    else        round_rate <= round_d;

  a_r4_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rate_valid |=> !rate_valid);
  a_r4_busy_covers_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rate_valid |-> busy);
  a_r4_accept_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  a_r1_bypass_result: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && ctrl3[0]) |=> (rate_valid && rate_out == PW'($past(parent_rate))));
  a_r5_round_not_above: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (round_rate <= $past(req_rate)));
endmodule

// File: tb/sim_pll_rate_calc.sv
module sim_pll_rate_calc;
  localparam logic [255:0] TBL = {
    32'd50000,  32'd0,      32'd126000, 32'd408000,
    32'd600000, 32'd816000, 32'd1008000, 32'd1200000};

  logic clk = 0, rst_n = 0, start = 0;
  logic [31:0] parent_rate = 0, req_rate = 0;
  logic [15:0] ctrl0 = 0, ctrl1 = 0, ctrl3 = 0;
  logic busy, rate_valid, pll_enabled;
  logic [45:0] rate_out;
  logic [31:0] round_rate;
  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  pll_rate_calc #(.RATE_TBL(TBL)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .parent_rate(parent_rate),
    .ctrl0(ctrl0), .ctrl1(ctrl1), .ctrl3(ctrl3), .req_rate(req_rate),
    .busy(busy), .rate_valid(rate_valid), .rate_out(rate_out),
    .pll_enabled(pll_enabled), .round_rate(round_rate));

  function automatic longint unsigned exp_rate(logic [31:0] p, logic [15:0] c0,
                                               logic [15:0] c1, logic [15:0] c3);
    longint unsigned r;
    if (c3[0]) return p;
    r = longint'(p) * (longint'(c1[12:0]) + 1);
    r = r / (longint'(c0[13:8]) + 1);
    return r / (longint'(c0[3:0]) + 1);
  endfunction

  function automatic longint unsigned exp_round(logic [31:0] q);
    longint unsigned t[6] = '{1200000, 1008000, 816000, 600000, 408000, 126000};
    for (int i = 0; i < 6; i++) if (t[i] <= q) return t[i];
    return t[5];
  endfunction

  task automatic chk(string rq, longint unsigned act, longint unsigned exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic run_calc(string rq, logic [31:0] p, logic [15:0] c0,
                          logic [15:0] c1, logic [15:0] c3, bit poke);
    longint unsigned e;
    int n;
    e = exp_rate(p, c0, c1, c3);
    @(negedge clk);
    parent_rate = p; ctrl0 = c0; ctrl1 = c1; ctrl3 = c3; start = 1;
    @(negedge clk);
    start = 0;
    chk({rq, " R4 busy after accept"}, busy, 1);
    if (poke && !rate_valid) begin
      parent_rate = ~p; ctrl0 = ~c0; ctrl1 = ~c1; ctrl3 = 16'h0001; start = 1;
      @(negedge clk);
      start = 0;
    end
    n = 0;
    while (!rate_valid && n < 400) begin @(negedge clk); n++; end
    chk({rq, " R4 valid seen"}, rate_valid, 1);
    chk(rq, rate_out, e);
    chk({rq, " R4 busy with valid"}, busy, 1);
    @(negedge clk);
    chk({rq, " R4 valid single cycle"}, rate_valid, 0);
    chk({rq, " R4 idle after"}, busy, 0);
  endtask

  task automatic run_round(string rq, logic [31:0] q);
    @(negedge clk);
    req_rate = q;
    @(negedge clk);
    chk(rq, round_rate, exp_round(q));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R4 watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R9 busy reset", busy, 0);
    chk("R9 valid reset", rate_valid, 0);
    chk("R9 rate reset", rate_out, 0);
    chk("R9 round reset", round_rate, 0);
    rst_n = 1;

    run_calc("R3 typical", 32'd24000, 16'h0000, 16'd49, 16'h0000, 0);
    run_calc("R3 unity", 32'd24000, 16'h0000, 16'h0000, 16'h0000, 0);
    run_calc("R3 max fields", 32'hFFFF_FFFF, 16'h3F0F, 16'h1FFF, 16'h0000, 0);
    run_calc("R3 min div max fb", 32'hFFFF_FFFF, 16'h0000, 16'h1FFF, 16'h0000, 0);
    run_calc("R1 bypass", 32'd24000, 16'h3F0F, 16'h1FFF, 16'h0001, 0);
    run_calc("R2 junk bits", 32'd27000, 16'hC0F3, 16'hE063, 16'hFFFC, 0);
    run_calc("R4 start while busy", 32'd98765, 16'h0502, 16'h0123, 16'h0000, 1);
    for (int i = 0; i < 30; i++) begin
      logic [15:0] c3r;
      c3r = 16'($urandom) & 16'hFFFE;
      if (i % 7 == 0) c3r[0] = 1'b1;
      run_calc("R3 random", $urandom, 16'($urandom), 16'($urandom), c3r, i % 5 == 0);
    end

    run_round("R5 above top", 32'hFFFF_FFFF);
    run_round("R5 exact", 32'd816000);
    run_round("R5 just above", 32'd816001);
    run_round("R5 just below", 32'd815999);
    run_round("R5 exact last live", 32'd126000);
    run_round("R7 below min, not trailing", 32'd60000);
    run_round("R6 zero request", 32'd0);
    run_round("R6 below min", 32'd125999);
    for (int i = 0; i < 40; i++) run_round("R5 random", $urandom % 32'd1400000);

    @(negedge clk); ctrl3 = 16'h0000; #1 chk("R8 enabled", pll_enabled, 1);
    @(negedge clk); ctrl3 = 16'h0002; #1 chk("R8 powered down", pll_enabled, 0);
    @(negedge clk); ctrl3 = 16'hFFFD; #1 chk("R8 other bits", pll_enabled, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule